// File: doc/BRIEF.md
# Banked Internal Data Memory Controller

This block is a 128-byte on-chip scratch memory with the address translation a small processor core needs in front of it. A single operation code picks one of three views of the same storage. Plain byte access uses an 8-bit address. Working-register access uses a 3-bit register index inside the bank that `bank_sel` names. Single-bit access addresses 128 flag bits packed into a fixed 16-byte window. An upward-growing stack is laid over the same array, and its 8-bit pointer is kept inside the block.

One operation is accepted per clock. The byte the operation reads is presented on `rd_data` one cycle later, together with a range flag. Bit operations return the selected bit in bit 0. Write operations return the content the location held before the write. Memory contents are not reset, so the owner must write every byte before it relies on a read.

Top module: `bank_ram_ctrl`

## Requirements
- R1: Op code 1 (byte read) and op code 2 (byte write) reach the byte at `addr` for any address 00h..7Fh. The read value appears on `rd_data` after the next rising edge.
- R2: Op code 3 (register read) and op code 4 (register write) address byte `bank_sel*8 + addr[2:0]`, so register n of bank b is byte b*8+n. Address bits above bit 2 are ignored.
- R3: A bank that `bank_sel` does not name still holds its data, and byte operations reach it at its plain address.
- R4: Bit number k (00h..7Fh) lives in byte 20h + k[6:3] at position k[2:0]. Op code 6 sets that bit and op code 7 clears it, and no other bit of the byte changes.
- R5: Op code 5 (bit read) returns the addressed bit on `rd_data[0]`, with all other bits of `rd_data` zero.
- R6: While `rst_n` is low, `sp` becomes 07h and `rd_data` and `addr_err` become zero.
- R7: Op code 8 (push) first increments `sp` by one and then stores `wr_data` at the new value. Starting from 07h, the first push writes byte 08h.
- R8: Op code 9 (pop) returns the byte at the current `sp` and then decrements `sp`. The pointer wraps modulo 256 in both directions.
- R9: If the effective address is 80h or above, `addr_err` is 1 after the edge, `rd_data` is zero, and no byte is written. This covers a byte address of 80h or more, a bit number of 80h or more, and a stack address of 80h or more. Every other non-idle operation clears `addr_err`.
- R10: A write operation (op codes 2, 4, 6, 7 and 8) returns on `rd_data` the old content of the target, or the old bit for op codes 6 and 7.
- R11: Op code 0 and the unused codes 10..15 leave memory, `sp`, `rd_data` and `addr_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 2 | Working-register bank used by register operations |
| op | input | 4 | Operation code for this cycle |
| addr | input | 8 | Byte address, register index or bit number |
| wr_data | input | 8 | Data for byte, register and push writes |
| rd_data | output | 8 | Data read by the last operation |
| sp | output | 8 | Current stack pointer |
| addr_err | output | 1 | Last operation's effective address was out of range |

## Verification
The in-line assertions check the following on every cycle: the pointer moves by exactly one on a push or pop and holds otherwise, an idle cycle freezes the outputs, an out-of-range result reads as zero and never writes, a bit operation lands inside the 16-byte window, and a set or clear flips at most one bit. These checks cannot show that data written through one view comes back through another. That includes register-to-byte aliasing across banks, a bit number landing in the intended byte, a pushed byte reappearing on pop after the pointer wraps, and write operations returning the old value. Those behaviours are only shown by the bench, which compares every cycle against its behavioural memory model.

// File: rtl/bmem_pkg.sv
`timescale 1ns/1ps
package bmem_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_BYTE_RD = 4'd1,
        OP_BYTE_WR = 4'd2,
        OP_REG_RD  = 4'd3,
        OP_REG_WR  = 4'd4,
        OP_BIT_RD  = 4'd5,
        OP_BIT_SET = 4'd6,
        OP_BIT_CLR = 4'd7,
        OP_PUSH    = 4'd8,
        OP_POP     = 4'd9
    } bmem_op_e;

    function automatic logic is_bit_op(input bmem_op_e o);
        return (o == OP_BIT_RD) || (o == OP_BIT_SET) || (o == OP_BIT_CLR);
    endfunction

    function automatic logic is_reg_op(input bmem_op_e o);
        return (o == OP_REG_RD) || (o == OP_REG_WR);
    endfunction

endpackage

// File: rtl/bmem_addr_map.sv
`timescale 1ns/1ps
module bmem_addr_map
    import bmem_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int DEPTH     = 128,
    parameter int BANKS     = 4,
    parameter int REGS      = 8,
    parameter int BIT_BASE  = 32,
    parameter int BIT_BYTES = 16
) (
    input  logic [3:0]                 op,
    input  logic [$clog2(BANKS)-1:0]   bank_sel,
    input  logic [AW-1:0]              addr,
    input  logic [AW-1:0]              sp_cur,
    output logic [AW-1:0]              tgt_addr,
    output logic [$clog2(DW)-1:0]      bit_pos,
    output logic                       oor
);
    localparam int REG_W     = $clog2(REGS);
    localparam int POS_W     = $clog2(DW);
    localparam int BSEL_W    = $clog2(BANKS);
    localparam int BIT_COUNT = BIT_BYTES * DW;

    bmem_op_e op_e;
    logic     bitno_oor;

    assign op_e = bmem_op_e'(op);

    always_comb begin
        tgt_addr  = addr;
        bit_pos   = addr[POS_W-1:0];
        bitno_oor = 1'b0;
        case (op_e)
            OP_REG_RD, OP_REG_WR:
                tgt_addr = AW'({bank_sel, addr[REG_W-1:0]});
            OP_BIT_RD, OP_BIT_SET, OP_BIT_CLR: begin
                tgt_addr  = AW'(BIT_BASE) + AW'(addr >> POS_W);
                bitno_oor = ({1'b0, addr} >= (AW+1)'(BIT_COUNT));
            end
            OP_PUSH:  tgt_addr = sp_cur + 1'b1;
            OP_POP:   tgt_addr = sp_cur;
            default:  tgt_addr = addr;
        endcase
        oor = bitno_oor || ({1'b0, tgt_addr} >= (AW+1)'(DEPTH));
    end

    always_comb begin
        if (is_bit_op(op_e) && !oor) begin
            AST_BIT_WINDOW: assert ((tgt_addr >= AW'(BIT_BASE)) &&
                                    (tgt_addr <  AW'(BIT_BASE + BIT_BYTES))); // R4
        end
        if (is_reg_op(op_e)) begin
            AST_REG_AREA: assert ({1'b0, tgt_addr} < (AW+1)'(BANKS * REGS)); // R2
        end
    end

    logic unused_bsel;
    assign unused_bsel = ^{BSEL_W{1'b0}};

endmodule

// File: rtl/bmem_bitop.sv
`timescale 1ns/1ps
module bmem_bitop #(
    parameter int DW = 8
) (
    input  logic [DW-1:0]          old_byte,
    input  logic [$clog2(DW)-1:0]  pos,
    input  logic                   set_val,
    output logic [DW-1:0]          new_byte,
    output logic                   sel_bit
);
    logic [DW-1:0] hit;

    for (genvar g = 0; g < DW; g++) begin : g_lane
        assign hit[g]      = (pos == g[$clog2(DW)-1:0]);
        assign new_byte[g] = hit[g] ? set_val : old_byte[g];
    end

    assign sel_bit = |(hit & old_byte);

    always_comb begin
        AST_ONE_BIT_CHANGED: assert ($countones(old_byte ^ new_byte) <= 1); // R4
    end

endmodule

// File: rtl/bmem_store.sv
`timescale 1ns/1ps
module bmem_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 128
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [$clog2(DEPTH)-1:0]  idx,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    assign rdata = mem_q[idx];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[idx] <= wdata;
        end
    end

endmodule

// File: rtl/bank_ram_ctrl.sv
`timescale 1ns/1ps
module bank_ram_ctrl
    import bmem_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int DEPTH     = 128,
    parameter int BANKS     = 4,
    parameter int REGS      = 8,
    parameter int BIT_BASE  = 32,
    parameter int BIT_BYTES = 16,
    parameter int SP_RESET  = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(BANKS)-1:0]   bank_sel,
    input  logic [3:0]                 op,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wr_data,
    output logic [DW-1:0]              rd_data,
    output logic [AW-1:0]              sp,
    output logic                       addr_err
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int POS_W = $clog2(DW);

    typedef struct packed {
        logic [AW-1:0] sp;
        logic [DW-1:0] rd;
        logic          err;
    } ctrl_state_t;

    ctrl_state_t   st_q, st_d;
    bmem_op_e      op_e;
    logic [AW-1:0] tgt_addr;
    logic [POS_W-1:0] bit_pos;
    logic          oor;
    logic [DW-1:0] ram_rd, ram_wd, bit_new;
    logic          ram_we, bit_old, set_val;

    assign op_e = bmem_op_e'(op);

    bmem_addr_map #(
        .AW(AW), .DW(DW), .DEPTH(DEPTH), .BANKS(BANKS), .REGS(REGS),
        .BIT_BASE(BIT_BASE), .BIT_BYTES(BIT_BYTES)
    ) u_map (
        .op       (op),
        .bank_sel (bank_sel),
        .addr     (addr),
        .sp_cur   (st_q.sp),
        .tgt_addr (tgt_addr),
        .bit_pos  (bit_pos),
        .oor      (oor)
    );

    bmem_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (ram_we),
        .idx   (tgt_addr[IDX_W-1:0]),
        .wdata (ram_wd),
        .rdata (ram_rd)
    );

    assign set_val = (op_e == OP_BIT_SET);

    bmem_bitop #(.DW(DW)) u_bitop (
        .old_byte (ram_rd),
        .pos      (bit_pos),
        .set_val  (set_val),
        .new_byte (bit_new),
        .sel_bit  (bit_old)
    );

    always_comb begin
        st_d   = st_q;
        ram_we = 1'b0;
        ram_wd = wr_data;
        case (op_e)
            OP_BYTE_RD, OP_REG_RD, OP_POP: begin
                st_d.rd  = oor ? '0 : ram_rd;
                st_d.err = oor;
            end
            OP_BYTE_WR, OP_REG_WR, OP_PUSH: begin
                st_d.rd  = oor ? '0 : ram_rd;
                st_d.err = oor;
                ram_we   = !oor;
            end
            OP_BIT_RD: begin
                st_d.rd  = oor ? '0 : DW'(bit_old);
                st_d.err = oor;
            end
            OP_BIT_SET, OP_BIT_CLR: begin
                st_d.rd  = oor ? '0 : DW'(bit_old);
                st_d.err = oor;
                ram_we   = !oor;
                ram_wd   = bit_new;
            end
            default: ;
        endcase
        if (op_e == OP_PUSH) st_d.sp = st_q.sp + 1'b1;
        if (op_e == OP_POP)  st_d.sp = st_q.sp - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sp  <= AW'(SP_RESET);
            st_q.rd  <= '0;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rd;
    assign sp       = st_q.sp;
    assign addr_err = st_q.err;

    AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_PUSH) |=> (sp == $past(sp) + 1'b1)); // R7
    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_POP) |=> (sp == $past(sp) - 1'b1)); // R8
    AST_SP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e != OP_PUSH && op_e != OP_POP) |=> $stable(sp)); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op > 4'd9 || op == 4'd0) |=> ($stable(rd_data) && $stable(addr_err))); // R11
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (rd_data == '0)); // R9
    AST_NO_WRITE_OOR: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !oor); // R9
    AST_BIT_RESULT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_BIT_RD) |=> (rd_data[DW-1:1] == '0)); // R5

endmodule

// File: tb/tb_bank_ram_ctrl.sv
`timescale 1ns/1ps
module tb_bank_ram_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_sel = 2'd0;
    logic [3:0] op = 4'd0;
    logic [7:0] addr = 8'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic [7:0] sp;
    logic       addr_err;

    int n_checks = 0;
    int n_fail   = 0;
    int ref_mem [128];
    int ref_sp  = 7;
    int ref_rd  = 0;
    int ref_err = 0;

    always #2.5 clk = ~clk;

    bank_ram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .op(op),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .sp(sp),
        .addr_err(addr_err)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model(input int o, input int b, input int a, input int d);
        int tgt, pos, old;
        bit oor;
        pos = 0;
        case (o)
            1, 2:    begin tgt = a; oor = (a >= 128); end
            3, 4:    begin tgt = b * 8 + (a % 8); oor = 0; end
            5, 6, 7: begin tgt = 32 + a / 8; pos = a % 8; oor = (a >= 128); end
            8:       begin tgt = (ref_sp + 1) % 256; oor = (tgt >= 128); end
            9:       begin tgt = ref_sp; oor = (tgt >= 128); end
            default: return;
        endcase
        old = oor ? 0 : ref_mem[tgt];
        ref_err = oor;
        if (oor) ref_rd = 0;
        else if (o >= 5 && o <= 7) ref_rd = (old < 0) ? -1 : ((old >> pos) & 1);
        else ref_rd = old;
        if (!oor) begin
            if (o == 2 || o == 4 || o == 8) ref_mem[tgt] = d;
            if (o == 6 && old >= 0) ref_mem[tgt] = old | (1 << pos);
            if (o == 7 && old >= 0) ref_mem[tgt] = old & ~(1 << pos) & 255;
        end
        if (o == 8) ref_sp = (ref_sp + 1) % 256;
        if (o == 9) ref_sp = (ref_sp + 255) % 256;
    endtask

    task automatic step(input int o, input int b, input int a, input int d, input string tag);
        op = 4'(o); bank_sel = 2'(b); addr = 8'(a); wr_data = 8'(d);
        @(posedge clk);
        model(o, b, a, d);
        @(negedge clk);
        check(tag, "sp", int'(sp), ref_sp);
        check(tag, "addr_err", int'(addr_err), ref_err);
        if (ref_rd >= 0) check(tag, "rd_data", int'(rd_data), ref_rd);
        op = 4'd0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) ref_mem[i] = -1;
        repeat (3) @(negedge clk);
        // R6: reset state
        check("R6", "sp", int'(sp), 7);
        check("R6", "rd_data", int'(rd_data), 0);
        check("R6", "addr_err", int'(addr_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: fill every byte, then read a spread of addresses
        for (int i = 0; i < 128; i++) step(2, 0, i, (i * 7 + 3) % 256, "R1");
        step(1, 0, 8'h00, 0, "R1");
        step(1, 0, 8'h3C, 0, "R1");
        step(1, 0, 8'h7F, 0, "R1");
        // R10: writes return the old content
        step(2, 0, 8'h40, 8'hEE, "R10");
        step(2, 0, 8'h40, 8'h11, "R10");
        // R2: register views into each bank, upper index bits ignored
        step(4, 2, 5, 8'hA5, "R2");
        step(1, 0, 8'h15, 0, "R2");
        step(4, 3, 8'hF7, 8'h5A, "R2");
        step(1, 0, 8'h1F, 0, "R2");
        step(3, 1, 2, 0, "R2");
        // R3: switch bank, old bank stays reachable by byte address
        step(4, 0, 1, 8'h3D, "R3");
        step(3, 1, 5, 0, "R3");
        step(1, 0, 8'h15, 0, "R3");
        step(1, 0, 8'h01, 0, "R3");
        // R4 / R5: set, clear, read bits
        step(6, 0, 8'h0B, 0, "R4");
        step(1, 0, 8'h21, 0, "R4");
        step(5, 0, 8'h0B, 0, "R5");
        step(7, 0, 8'h0B, 0, "R4");
        step(1, 0, 8'h21, 0, "R4");
        step(7, 0, 8'h00, 0, "R4");
        step(6, 0, 8'h7F, 0, "R4");
        step(1, 0, 8'h2F, 0, "R4");
        step(5, 0, 8'h7F, 0, "R5");
        step(5, 0, 8'h01, 0, "R5");
        // R9: out-of-range byte and bit addresses
        step(2, 0, 8'h90, 8'h77, "R9");
        step(1, 0, 8'hFF, 0, "R9");
        step(6, 0, 8'h80, 0, "R9");
        step(1, 0, 8'h10, 0, "R9");
        // R7: push from reset pointer lands at 08h
        step(8, 0, 0, 8'hC1, "R7");
        step(8, 0, 0, 8'hC2, "R7");
        step(1, 0, 8'h08, 0, "R7");
        // R8: pops in reverse order, then wrap below zero
        step(9, 0, 0, 0, "R8");
        step(9, 0, 0, 0, "R8");
        for (int i = 0; i < 8; i++) step(9, 0, 0, 0, "R8");
        step(9, 0, 0, 0, "R9");
        step(8, 0, 0, 8'h99, "R9");
        step(8, 0, 0, 8'h4E, "R8");
        step(1, 0, 8'h00, 0, "R8");
        step(9, 0, 0, 0, "R8");
        // R11: idle and unused codes change nothing
        step(0, 0, 8'h05, 8'h33, "R11");
        step(12, 0, 8'h05, 8'h33, "R11");
        step(15, 0, 8'h05, 8'h33, "R11");
        step(1, 0, 8'h05, 0, "R11");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule